// File: doc/BRIEF.md
# Multi-Counter Performance Monitor Unit

This block counts hardware activity for profiling. It holds one 32-bit cycle counter and four 32-bit event counters. Each event counter picks one line of a 256-wide vector of single-cycle event pulses from the core by an 8-bit event code. Software reaches every register through a small synchronous register bus, with an address, a write strobe, write data and registered read data.

To take a sample every N events, software loads a counter with the two's complement of N. The counter then wraps after N events. Each wrap latches a sticky overflow flag. Flags are cleared by writing ones to them. A single level interrupt is raised while any flag is set whose enable bit is also set. A divide-by-64 option slows the cycle counter for long measurement windows.

Register map, by word address on `bus_addr`: 0 control, 1 event select, 2 interrupt enable, 3 overflow flags, 4 cycle counter, 5 to 8 event counters 0 to 3. Any other address reads as zero.

Top module: `perf_mon_unit`

## Requirements
- R1: After synchronous reset every register and counter reads 0 and `irq` is low. Unmapped addresses (9 to 15) always read 0.
- R2: While control bit 0 (global enable) is 0, no counter changes except through a bus write.
- R3: When enabled, the cycle counter advances by one on every clock. When control bit 3 is also set, it advances only once per 64 clocks, counted from the last cycle-counter reset.
- R4: Event counter i takes its code from event-select bits [8i+7:8i]. While enabled, it increments by exactly one in each cycle in which `evt_pulse[code]` is high.
- R5: Event codes 0xFF (unused), 0x0E, 0x0F and 0x13 (reserved) never increment their counter.
- R6: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag: bit 0 for the cycle counter, bit 1+i for event counter i. A set flag stays set across later overflows of the same counter or of any other counter.
- R7: Writing the overflow-flag register clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. If a clear and a new overflow of the same counter fall in the same cycle, the flag ends up set.
- R8: `irq` is a registered output. It is high one cycle after any flag is set together with its matching interrupt-enable bit (same bit layout as the flags), and it falls one cycle after that condition ends.
- R9: Writing control bit 1 zeroes all event counters, and writing bit 2 zeroes the cycle counter and its divide-by-64 phase. Both bits act in the write cycle only. They read back as 0, and they do not touch the overflow flags. Control reads return only bits 0 and 3; writes to bits 24 to 31 are ignored.
- R10: A bus write to a counter in the same cycle as its increment leaves exactly the written value.
- R11: `bus_rdata` presents the register addressed by `bus_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 256 | Single-cycle event pulses, indexed by event code |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench targets the following corner cases, and what a faulty design would show for each:
- Clear and overflow in one cycle: a design that lets the write-one-to-clear win loses a sample.
- Second overflow: a design that rebuilds the flag vector from the latest wrap alone drops the older pending flag.
- Counter write racing an event: here a wrong priority leaves the written value plus one.
- Reserved and unused codes: with all 256 event lines high, a design that does not filter them counts on a dead counter.
- Divide-by-64 phase: a prescaler that is not cleared with the cycle counter gives a count that differs from the floor of the enabled cycles over 64.
- Interrupt timing: the bench checks the one-cycle latency of `irq`, so a combinational or two-stage interrupt path shows up at once.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CODE_W = 8;
  localparam int EV_W   = 1 << CODE_W;

  // register word addresses
  localparam int A_CTRL = 0;
  localparam int A_SEL  = 1;
  localparam int A_IEN  = 2;
  localparam int A_OVF  = 3;
  localparam int A_CYC  = 4;
  localparam int A_EVT0 = 5;

  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_EVRST = 1;
  localparam int CB_CYRST = 2;
  localparam int CB_DIV   = 3;

  // codes that never count: unused marker and reserved slots
  function automatic logic is_dead_code(input logic [CODE_W-1:0] code);
    return (code == '1) || (code == 8'h0E) || (code == 8'h0F) || (code == 8'h13);
  endfunction
endpackage

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int CNT_W = 32,
  parameter int DIV   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             div_mode,
  input  logic             clr,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre;
  logic             tick;

  assign tick = en && (!div_mode || pre == PRE_LAST);
  assign wrap = tick && !wr && !clr && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
    end else if (clr) begin
      pre <= '0;
    end else if (en) begin
      pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wr)   cnt <= wdata;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [EV_W-1:0]   events,
  input  logic              clr,
  input  logic              wr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap
);
  logic hit;

  assign hit  = en && events[code] && !is_dead_code(code);
  assign wrap = hit && !wr && !clr && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (wr)  cnt <= wdata;
    else if (clr) cnt <= '0;
    else if (hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmu_overflow_flags.sv
module pmu_overflow_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] keep;

  assign keep = clr_wr ? ~clr_mask : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & keep) | set;
      irq   <= |(flags & ien);
    end
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 4,
  parameter int ADDR_W  = 4,
  parameter int CYC_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [EV_W-1:0]   evt_pulse,
  output logic              irq
);
  localparam int NFLAG = NUM_EVT + 1;
  localparam int SEL_W = NUM_EVT * CODE_W;

  logic                            ctrl_en, ctrl_div;
  logic [SEL_W-1:0]                evtsel;
  logic [NFLAG-1:0]                ien_q;
  logic [NFLAG-1:0]                flags;
  logic [CNT_W-1:0]                cyc_cnt;
  logic                            cyc_wrap;
  logic [NUM_EVT-1:0][CNT_W-1:0]   evt_cnt;
  logic [NUM_EVT-1:0]              evt_wrap;
  logic                            wr_ctrl, wr_sel, wr_ien, wr_ovf, wr_cyc;
  logic [CNT_W-1:0]                rd_next;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_sel  = bus_wr && (bus_addr == ADDR_W'(A_SEL));
  assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(A_IEN));
  assign wr_ovf  = bus_wr && (bus_addr == ADDR_W'(A_OVF));
  assign wr_cyc  = bus_wr && (bus_addr == ADDR_W'(A_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_div <= 1'b0;
      evtsel   <= '0;
      ien_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= bus_wdata[CB_EN];
        ctrl_div <= bus_wdata[CB_DIV];
      end
      if (wr_sel) evtsel <= bus_wdata[SEL_W-1:0];
      if (wr_ien) ien_q  <= bus_wdata[NFLAG-1:0];
    end
  end

  pmu_cycle_counter #(.CNT_W(CNT_W), .DIV(CYC_DIV)) cyc_i (
    .clk      (clk),
    .rst      (rst),
    .en       (ctrl_en),
    .div_mode (ctrl_div),
    .clr      (wr_ctrl && bus_wdata[CB_CYRST]),
    .wr       (wr_cyc),
    .wdata    (bus_wdata),
    .cnt      (cyc_cnt),
    .wrap     (cyc_wrap)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    pmu_event_counter #(.CNT_W(CNT_W)) evt_i (
      .clk    (clk),
      .rst    (rst),
      .en     (ctrl_en),
      .code   (evtsel[i*CODE_W +: CODE_W]),
      .events (evt_pulse),
      .clr    (wr_ctrl && bus_wdata[CB_EVRST]),
      .wr     (bus_wr && (bus_addr == ADDR_W'(A_EVT0 + i))),
      .wdata  (bus_wdata),
      .cnt    (evt_cnt[i]),
      .wrap   (evt_wrap[i])
    );
  end

  pmu_overflow_flags #(.N(NFLAG)) ovf_i (
    .clk      (clk),
    .rst      (rst),
    .set      ({evt_wrap, cyc_wrap}),
    .clr_wr   (wr_ovf),
    .clr_mask (bus_wdata[NFLAG-1:0]),
    .ien      (ien_q),
    .flags    (flags),
    .irq      (irq)
  );

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) begin
      rd_next[CB_EN]  = ctrl_en;
      rd_next[CB_DIV] = ctrl_div;
    end
    if (bus_addr == ADDR_W'(A_SEL)) rd_next[SEL_W-1:0] = evtsel;
    if (bus_addr == ADDR_W'(A_IEN)) rd_next[NFLAG-1:0] = ien_q;
    if (bus_addr == ADDR_W'(A_OVF)) rd_next[NFLAG-1:0] = flags;
    if (bus_addr == ADDR_W'(A_CYC)) rd_next = cyc_cnt;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (bus_addr == ADDR_W'(A_EVT0 + k)) rd_next = evt_cnt[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 4,
  parameter int ADDR_W  = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [CNT_W-1:0]              wdata,
  input logic                          ctrl_en,
  input logic                          ctrl_div,
  input logic [NUM_EVT*CODE_W-1:0]     evtsel,
  input logic [NUM_EVT:0]              ien,
  input logic [NUM_EVT:0]              flags,
  input logic [CNT_W-1:0]              cyc_cnt,
  input logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt,
  input logic                          irq
);
  logic [NUM_EVT:0] clr_seen;

  always_comb begin
    clr_seen = '0;
    if (wr_en && addr == ADDR_W'(A_OVF)) clr_seen = wdata[NUM_EVT:0];
  end

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl_en) && !$past(wr_en)) |-> ($stable(cyc_cnt) && $stable(evt_cnt)));

  // R3
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_en) && !$past(ctrl_div) && !$past(wr_en)) |-> (cyc_cnt == $past(cyc_cnt) + CNT_W'(1)));

  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(flags) & ~$past(clr_seen) & ~flags) == '0));

  // R6
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cyc_cnt) == '1 && cyc_cnt == '0 && !$past(wr_en)) |-> flags[0]);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(flags & ien)));

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_dead
    // R5
    dead_code_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(is_dead_code(evtsel[i*CODE_W +: CODE_W])) && !$past(wr_en)) |-> $stable(evt_cnt[i]));
  end
endmodule

bind perf_mon_unit pmu_checker #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (bus_wr),
  .addr     (bus_addr),
  .wdata    (bus_wdata),
  .ctrl_en  (ctrl_en),
  .ctrl_div (ctrl_div),
  .evtsel   (evtsel),
  .ien      (ien_q),
  .flags    (flags),
  .cyc_cnt  (cyc_cnt),
  .evt_cnt  (evt_cnt),
  .irq      (irq)
);

// File: tb/perf_mon_unit_tb.sv
`timescale 1ns/1ps
module perf_mon_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [255:0] evt_pulse = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  perf_mon_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_ev(input logic [3:0] a, input logic [31:0] d, input logic [255:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_pulse = v;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; evt_pulse = '0;
  endtask

  task automatic pulse_vec(input logic [255:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(posedge clk);
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic pulse(input int code);
    logic [255:0] v;
    v = '0;
    v[code] = 1'b1;
    pulse_vec(v);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reset/unmapped read addr %0d", a), v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(4'd0, 32'h0000_000F);
    rd(4'd0, v);
    chk("R9 ctrl read keeps only bits 0,3", v, 32'h9);
    wr(4'd0, 32'hFF00_0008);
    rd(4'd0, v);
    chk("R9 ctrl upper byte ignored", v, 32'h8);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_cycle();
    logic [31:0] v;
    wr(4'd4, 32'd100);
    evt_pulse = '1;
    repeat (20) @(posedge clk);
    @(negedge clk) evt_pulse = '0;
    rd(4'd4, v);
    chk("R2 cycle counter frozen when disabled", v, 32'd100);
    rd(4'd5, v);
    chk("R2 event counter frozen when disabled", v, 32'd0);
    wr(4'd0, 32'h1);
    repeat (49) @(posedge clk);
    wr(4'd0, 32'h0);
    rd(4'd4, v);
    chk("R3 cycle counter counts every clock", v, 32'd150);
    wr(4'd0, 32'hD);
    repeat (199) @(posedge clk);
    wr(4'd0, 32'h0);
    rd(4'd4, v);
    chk("R3 divide-by-64 count", v, 32'd3);
  endtask

  task automatic t_events();
    logic [31:0] v;
    logic [255:0] both;
    wr(4'd1, 32'hFF07_0B05);
    rd(4'd1, v);
    chk("R11 event select readback", v, 32'hFF07_0B05);
    wr(4'd0, 32'h3);
    repeat (3) pulse(8'h05);
    repeat (2) pulse(8'h0B);
    pulse(8'h07);
    both = '0; both[5] = 1'b1; both[7] = 1'b1;
    pulse_vec(both);
    pulse(8'hFF);
    pulse(8'h06);
    wr(4'd0, 32'h0);
    rd(4'd5, v); chk("R4 lane0 code 0x05 count", v, 32'd4);
    rd(4'd6, v); chk("R4 lane1 code 0x0B count", v, 32'd2);
    rd(4'd7, v); chk("R4 lane2 code 0x07 count", v, 32'd2);
    rd(4'd8, v); chk("R5 lane3 code 0xFF stays 0", v, 32'd0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(4'd1, 32'h130F_0E00);
    wr(4'd0, 32'h3);
    pulse(8'h00); pulse(8'h0E); pulse(8'h0F); pulse(8'h13);
    pulse_vec('1);
    wr(4'd0, 32'h0);
    rd(4'd5, v); chk("R4 code 0x00 counts", v, 32'd2);
    rd(4'd6, v); chk("R5 reserved 0x0E", v, 32'd0);
    rd(4'd7, v); chk("R5 reserved 0x0F", v, 32'd0);
    rd(4'd8, v); chk("R5 reserved 0x13", v, 32'd0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(4'd1, 32'hFFFF_05FF);
    wr(4'd6, 32'hFFFF_FFFE);
    wr(4'd0, 32'h1);
    pulse(8'h05);
    rd(4'd3, v); chk("R6 no flag before wrap", v, 32'h0);
    pulse(8'h05);
    rd(4'd3, v); chk("R6 event counter 1 wrap sets bit 2", v, 32'h4);
    rd(4'd6, v); chk("R6 counter wrapped to 0", v, 32'h0);
    wr(4'd4, 32'hFFFF_FFF0);
    repeat (30) @(posedge clk);
    rd(4'd3, v); chk("R6 cycle wrap sets bit 0, bit 2 kept", v, 32'h5);
    wr(4'd6, 32'hFFFF_FFFF);
    pulse(8'h05);
    rd(4'd3, v); chk("R6 repeat overflow keeps flags", v, 32'h5);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    logic [255:0] e5;
    wr(4'd3, 32'h0);
    rd(4'd3, v); chk("R7 write 0 leaves flags", v, 32'h5);
    wr(4'd3, 32'h4);
    rd(4'd3, v); chk("R7 clear bit 2 only", v, 32'h1);
    wr(4'd3, 32'h1);
    rd(4'd3, v); chk("R7 clear bit 0", v, 32'h0);
    wr(4'd1, 32'hFFFF_FF05);
    wr(4'd5, 32'hFFFF_FFFF);
    e5 = '0; e5[5] = 1'b1;
    wr_ev(4'd3, 32'h2, e5);
    rd(4'd3, v); chk("R7 overflow beats same-cycle clear", v, 32'h2);
    wr(4'd0, 32'h7);
    rd(4'd3, v); chk("R9 counter reset keeps flags", v, 32'h2);
    rd(4'd5, v); chk("R9 event reset zeroes counter", v, 32'h0);
    rd(4'd0, v); chk("R9 reset bits self-clear on read", v, 32'h1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(4'd2, 32'h2);
    chk("R8 irq not yet high (one-cycle latency)", {31'b0, irq}, 32'h0);
    @(posedge clk); #1;
    chk("R8 irq high for enabled flag", {31'b0, irq}, 32'h1);
    wr(4'd2, 32'h1);
    @(posedge clk); #1;
    chk("R8 irq low with non-matching enable", {31'b0, irq}, 32'h0);
    wr(4'd2, 32'h2);
    wr(4'd3, 32'h2);
    @(posedge clk); #1;
    chk("R8 irq low after flag cleared", {31'b0, irq}, 32'h0);
    rd(4'd2, v); chk("R11 interrupt enable readback", v, 32'h2);
  endtask

  task automatic t_write_wins();
    logic [31:0] v;
    logic [255:0] e5;
    e5 = '0; e5[5] = 1'b1;
    wr(4'd5, 32'd10);
    wr_ev(4'd5, 32'd500, e5);
    pulse(8'h05);
    wr(4'd0, 32'h0);
    rd(4'd5, v); chk("R10 written value wins, then one event", v, 32'd501);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_ctrl();
    t_cycle();
    t_events();
    t_reserved();
    t_overflow();
    t_w1c();
    t_irq();
    t_write_wins();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule